// File: doc/BRIEF.md
# Programmable Oversampling Baud Timer

This block derives the oversampling clock enable for a serial receiver or transmitter from a chosen counting source. A 16-bit divisor is split across two byte-wide preset registers. A small command port writes and reads those registers, selects the counting source and the output mode, and starts or halts the counter.

The counter steps only on qualified cycles. A qualified cycle is every system clock cycle, or, when the external source is selected, only those cycles in which the external enable input is high.

- In square-wave mode the output level flips after every `n` qualified steps, so one full wave spans `2n` steps.
- In pulse mode a one-cycle pulse is emitted every `n` steps. For the same divisor this gives twice the rate of square-wave mode.

A 16x tick marks each output period, and a bit-rate tick is derived from every sixteenth 16x tick.

Top module: `baud_timer`

## Requirements
- R1: After reset `x16_tick`, `tmr_out`, `bit_tick` and `rd_data` are 0, both preset bytes read 0, the mode is square-wave and the source is the system clock.
- R2: Command codes on `cmd_op` (acted on when `cmd_valid` is high) are:
  - 0 = start
  - 1 = stop
  - 2 = write low preset byte
  - 3 = write high preset byte
  - 4 = read low preset byte
  - 5 = read high preset byte
  - 6 = write config (`cmd_wdata[0]` = pulse mode, `cmd_wdata[1]` = external source)
  - 7 = no effect

  A read puts the byte on `rd_data` in the cycle after the command, and `rd_data` holds it until the next read.
- R3: In square-wave mode `x16_tick` recurs every `2n` qualified steps, and `tmr_out` is high for `n` steps and low for `n` steps.
- R4: In pulse mode `x16_tick` recurs every `n` qualified steps, and `tmr_out` is high for exactly the cycle of each tick.
- R5: A divisor of 1 is legal. It gives a tick every 2 steps in square-wave mode and a tick every step in pulse mode.
- R6: A divisor of 0 counts as 65536.
- R7: A preset write does not change the period already in progress. The new value is used from the next reload onward, and a reload in the same cycle as the write still uses the old value.
- R8: Stop clears the counter and holds `tmr_out`, `x16_tick` and `bit_tick` at 0 until the next start.
- R9: Start loads the preset and sets the output low. If start is captured at clock edge S, the first `x16_tick` is visible after the edge that completes the n-th qualified step following S.
- R10: With the external source selected, only cycles with `ext_clk_en` high count as steps.
- R11: `bit_tick` is high for one cycle, in the cycle after every sixteenth `x16_tick`. Its phase counter is cleared by start and by stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_en | input | 1 | External counting enable, used when the external source is selected |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_wdata | input | 8 | Write data for preset and config commands |
| rd_data | output | 8 | Last preset byte read |
| x16_tick | output | 1 | One-cycle pulse per 16x period |
| tmr_out | output | 1 | Square wave, or a copy of the pulse in pulse mode |
| bit_tick | output | 1 | One-cycle pulse per bit period |

## Verification
Two events can land on the same clock edge: a preset write and a counter reload. To provoke this, the bench issues the write so that it is captured on exactly the edge where the running period ends. It then predicts the later tick positions from the old divisor for the period that follows and from the new divisor afterwards. A write captured earlier in the period is also checked, to confirm that the current period is not shortened. Tick positions are compared with cycle numbers computed arithmetically from the divisor, the mode and the enable pattern.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_STOP   = 3'd1,
        OP_WR_LO  = 3'd2,
        OP_WR_HI  = 3'd3,
        OP_RD_LO  = 3'd4,
        OP_RD_HI  = 3'd5,
        OP_WR_CFG = 3'd6,
        OP_NONE   = 3'd7
    } bt_op_e;
endpackage

// File: rtl/bt_regs.sv
module bt_regs
    import baud_timer_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [DIV_W/2-1:0] cmd_wdata,
    output logic [DIV_W-1:0] preset,
    output logic             mode_pulse,
    output logic             src_ext,
    output logic             start_p,
    output logic             stop_p,
    output logic [DIV_W/2-1:0] rd_data
);
    localparam int BYTE_W = DIV_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] rd;
        logic              pulse;
        logic              ext;
    } reg_s;

    reg_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        start_p = 1'b0;
        stop_p  = 1'b0;
        if (cmd_valid) begin
            case (bt_op_e'(cmd_op))
                OP_START:  start_p = 1'b1;
                OP_STOP:   stop_p  = 1'b1;
                OP_WR_LO:  r_d.lo  = cmd_wdata;
                OP_WR_HI:  r_d.hi  = cmd_wdata;
                OP_RD_LO:  r_d.rd  = r_q.lo;
                OP_RD_HI:  r_d.rd  = r_q.hi;
                OP_WR_CFG: begin
                    r_d.pulse = cmd_wdata[0];
                    r_d.ext   = cmd_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign preset     = {r_q.hi, r_q.lo};
    assign mode_pulse = r_q.pulse;
    assign src_ext    = r_q.ext;
    assign rd_data    = r_q.rd;

    // R2
    rd_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RD_HI) |=> rd_data == $past(preset[DIV_W-1:BYTE_W]));
    // R2
    rd_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RD_LO) |=> rd_data == $past(preset[BYTE_W-1:0]));
endmodule

// File: rtl/bt_divider.sv
module bt_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             mode_pulse,
    input  logic [DIV_W-1:0] preset,
    output logic             x16_tick,
    output logic             tmr_out
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << DIV_W;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             tick;
    } div_s;

    div_s s_d, s_q;
    logic [CNT_W-1:0] n_eff;

    assign n_eff = (preset == '0) ? FULL : {1'b0, preset};

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (stop_p) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
            s_d.out = 1'b0;
        end else if (start_p) begin
            s_d.run = 1'b1;
            s_d.cnt = n_eff;
            s_d.out = 1'b0;
        end else begin
            if (mode_pulse) s_d.out = 1'b0;
            if (s_q.run && step_en) begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.cnt = n_eff;
                    if (mode_pulse) begin
                        s_d.out  = 1'b1;
                        s_d.tick = 1'b1;
                    end else begin
                        s_d.out  = ~s_q.out;
                        s_d.tick = ~s_q.out;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign x16_tick = s_q.tick;
    assign tmr_out  = s_q.out;

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!x16_tick && !tmr_out));
    // R3
    tick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x16_tick |-> tmr_out);
    // R9
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p && !stop_p) |=> (!tmr_out && s_q.run && s_q.cnt != '0));
    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL);
endmodule

// File: rtl/bt_bitdiv.sv
module bt_bitdiv #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic x16_in,
    output logic bit_tick
);
    localparam int PH_W = $clog2(RATIO);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            tick;
    } ph_s;

    ph_s p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.tick = 1'b0;
        if (clr) begin
            p_d.ph = '0;
        end else if (x16_in) begin
            if (p_q.ph == PH_W'(RATIO - 1)) begin
                p_d.ph   = '0;
                p_d.tick = 1'b1;
            end else begin
                p_d.ph = p_q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bit_tick = p_q.tick;

    // R11
    bit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(x16_in));
    // R11
    bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !bit_tick);
endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int DIV_W = 16,
    parameter int RATIO = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_clk_en,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [7:0]   cmd_wdata,
    output logic [7:0]   rd_data,
    output logic         x16_tick,
    output logic         tmr_out,
    output logic         bit_tick
);
    logic [DIV_W-1:0] preset;
    logic             mode_pulse, src_ext, start_p, stop_p, step_en;

    bt_regs #(.DIV_W(DIV_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .preset(preset), .mode_pulse(mode_pulse),
        .src_ext(src_ext), .start_p(start_p), .stop_p(stop_p), .rd_data(rd_data)
    );

    assign step_en = src_ext ? ext_clk_en : 1'b1;

    bt_divider #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .start_p(start_p),
        .stop_p(stop_p), .mode_pulse(mode_pulse), .preset(preset),
        .x16_tick(x16_tick), .tmr_out(tmr_out)
    );

    bt_bitdiv #(.RATIO(RATIO)) i_bit (
        .clk(clk), .rst_n(rst_n), .clr(start_p | stop_p), .x16_in(x16_tick),
        .bit_tick(bit_tick)
    );

    // R10
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && !ext_clk_en && !start_p && !stop_p && !x16_tick) |=> !x16_tick);
endmodule

// File: tb/test_baud_timer.sv
module test_baud_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd7;
    logic [7:0] cmd_wdata = 8'd0;
    logic       ext_clk_en;
    logic [7:0] rd_data;
    logic       x16_tick, tmr_out, bit_tick;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int ref_cyc = 0;
    int win_len = 0;
    int win_lo = 0;
    int win_hi = 0;
    int tick_n = 0;
    int bit_n = 0;
    int hi_cnt = 0;
    int tick_log [0:255];
    int bit_log [0:255];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign ext_clk_en = (cyc % 3 == 0);

    baud_timer i_baud_timer (
        .clk(clk), .rst_n(rst_n), .ext_clk_en(ext_clk_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .x16_tick(x16_tick), .tmr_out(tmr_out), .bit_tick(bit_tick)
    );

    always @(negedge clk) if (rst_n) begin
        if (x16_tick && tick_n < 256) begin
            tick_log[tick_n] <= cyc;
            tick_n <= tick_n + 1;
        end
        if (bit_tick && bit_n < 256) begin
            bit_log[bit_n] <= cyc;
            bit_n <= bit_n + 1;
        end
        if (tmr_out && cyc > win_lo && cyc <= win_hi) hi_cnt <= hi_cnt + 1;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(logic [2:0] op, logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = data;
        ref_cyc   = cyc + 1;
        if (op == 3'd0) begin
            win_lo = ref_cyc;
            win_hi = ref_cyc + win_len;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd7;
    endtask

    task automatic set_div(int n, bit pulse, bit ext);
        cmd(3'd2, 8'(n));
        cmd(3'd3, 8'(n >> 8));
        cmd(3'd6, {6'd0, ext, pulse});
    endtask

    task automatic stop_idle();
        cmd(3'd1, 8'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_rate(int n, bit pulse);
        int t0, h0, s, per, cnt;
        string tag;
        set_div(n, pulse, 1'b0);
        win_len = 4 * n;
        t0 = tick_n;
        h0 = hi_cnt;
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        repeat (4 * n + 2) @(negedge clk);
        stop_idle();
        per = pulse ? n : 2 * n;
        tag = (n == 1) ? "R5" : (pulse ? "R4" : "R3");
        chk(tick_log[t0] == s + n, "R9 first tick", tick_log[t0] - s, n);
        chk(tick_log[t0 + 1] == s + n + per, tag, tick_log[t0 + 1] - s, n + per);
        cnt = 0;
        for (int i = t0; i < tick_n; i++) if (tick_log[i] <= s + 4 * n) cnt++;
        chk(cnt == (pulse ? 4 : 2), tag, cnt, pulse ? 4 : 2);
        chk(hi_cnt - h0 == (pulse ? 4 : 2 * n), tag, hi_cnt - h0, pulse ? 4 : 2 * n);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int s, t0, b0, m, c, e1, e2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(x16_tick == 0 && tmr_out == 0 && bit_tick == 0, "R1", {x16_tick, tmr_out, bit_tick}, 0);
        chk(rd_data == 0, "R1", rd_data, 0);
        cmd(3'd5, 8'd0);
        chk(rd_data == 0, "R1", rd_data, 0);
        // R2 preset write and readback
        cmd(3'd2, 8'hA5);
        cmd(3'd3, 8'h3C);
        cmd(3'd4, 8'd0);
        chk(rd_data == 8'hA5, "R2", rd_data, 8'hA5);
        cmd(3'd5, 8'd0);
        chk(rd_data == 8'h3C, "R2", rd_data, 8'h3C);
        cmd(3'd7, 8'hFF);
        chk(rd_data == 8'h3C, "R2", rd_data, 8'h3C);

        // R3 R4 R5 R9 sweep
        foreach (tick_log[i]) tick_log[i] = 0;
        for (int k = 0; k < 6; k++) begin
            int nv;
            nv = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 5 : (k == 4) ? 7 : 16;
            check_rate(nv, 1'b0);
            check_rate(nv, 1'b1);
        end

        // R7 write mid-period
        set_div(10, 1'b0, 1'b0);
        t0 = tick_n;
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        cmd(3'd2, 8'd4);
        repeat (24) @(negedge clk);
        stop_idle();
        chk(tick_log[t0] == s + 10, "R7", tick_log[t0] - s, 10);
        chk(tick_log[t0 + 1] == s + 18, "R7", tick_log[t0 + 1] - s, 18);

        // R7 write landing on the reload edge
        set_div(6, 1'b0, 1'b0);
        t0 = tick_n;
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        repeat (4) @(negedge clk);
        cmd(3'd2, 8'd3);
        chk(ref_cyc == s + 6, "R7 setup", ref_cyc - s, 6);
        repeat (20) @(negedge clk);
        stop_idle();
        chk(tick_log[t0] == s + 6, "R7", tick_log[t0] - s, 6);
        chk(tick_log[t0 + 1] == s + 15, "R7", tick_log[t0 + 1] - s, 15);

        // R8 stop silences outputs
        set_div(3, 1'b1, 1'b0);
        cmd(3'd0, 8'd0);
        repeat (10) @(negedge clk);
        stop_idle();
        t0 = tick_n;
        b0 = bit_n;
        c = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tmr_out) c++;
        end
        chk(tick_n == t0, "R8", tick_n - t0, 0);
        chk(c == 0, "R8", c, 0);

        // R10 external source, enable every third cycle
        set_div(4, 1'b1, 1'b1);
        t0 = tick_n;
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        repeat (40) @(negedge clk);
        stop_idle();
        c = 0; e1 = 0; e2 = 0;
        for (m = s + 1; m < s + 40; m++) begin
            if ((m - 1) % 3 == 0) begin
                c++;
                if (c == 4) e1 = m;
                if (c == 8) e2 = m;
            end
        end
        chk(tick_log[t0] == e1, "R10", tick_log[t0], e1);
        chk(tick_log[t0 + 1] == e2, "R10", tick_log[t0 + 1], e2);

        // R6 divisor 0 means 65536
        set_div(0, 1'b1, 1'b0);
        t0 = tick_n;
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        repeat (65540) @(negedge clk);
        stop_idle();
        chk(tick_n - t0 == 1, "R6", tick_n - t0, 1);
        chk(tick_log[t0] == s + 65536, "R6", tick_log[t0] - s, 65536);

        // R11 bit tick every 16 x16 ticks
        set_div(1, 1'b1, 1'b0);
        b0 = bit_n;
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        repeat (40) @(negedge clk);
        stop_idle();
        chk(bit_log[b0] == s + 17, "R11", bit_log[b0] - s, 17);
        chk(bit_log[b0 + 1] == s + 33, "R11", bit_log[b0 + 1] - s, 33);
        // R11 phase cleared by restart
        b0 = bit_n;
        cmd(3'd0, 8'd0);
        repeat (5) @(negedge clk);
        cmd(3'd0, 8'd0);
        s = ref_cyc;
        repeat (20) @(negedge clk);
        stop_idle();
        chk(bit_log[b0] == s + 17, "R11", bit_log[b0] - s, 17);
        chk(bit_n - b0 == 1, "R11", bit_n - b0, 1);

        finish_run();
    end
endmodule